// File: doc/BRIEF.md
# Serial Write Frame Builder

This block turns one write request into a fixed-length serial frame for a chip-to-chip link. A producer offers a command header, a 32-bit target address, write data and a size code over a valid/ready handshake. On acceptance the block works out which byte lanes the write covers from the low address bits and the size. It moves the data into those lanes and clears the others. It stamps the size code into the header and computes a CRC-16 over header, address and data. It then shifts the 96-bit result out one bit per clock, most significant bit first.

While a frame is going out the handshake is closed. A serial-valid strobe marks every bit slot, and a single-cycle done pulse follows the final CRC bit. The decoded lane-enable mask is held on an output for the whole frame, so a testbench or a neighbouring block can inspect the lane decode separately from the serial stream. Line coding, link encapsulation and any receive side belong to other blocks.

Top module: `wr_frame_tx`

## Requirements
- R1: A frame is 96 bits sent MSB first: header (16), then address (32, all bits passed unchanged), then data (32), then CRC (16).
- R2: The header is sent as `in_hdr` with bits [1:0] replaced by the effective size code: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit.
- R3: For size code 00, address bits [1:0] pick one lane: 00 selects byte 3 (data bits 31:24), 01 byte 2, 10 byte 1, 11 byte 0. `byte_en` bit n is set for byte n, and `in_data[7:0]` is placed in that lane.
- R4: For size code 01, address bit 0 = 0 selects the upper half-word (`byte_en` = 1100, data bits 31:16) and 1 selects the lower (`byte_en` = 0011, bits 15:0). `in_data[15:0]` is placed there.
- R5: For size code 10, `byte_en` = 1111 and `in_data` is sent as is, whatever address bits [1:0] hold.
- R6: In 8-bit and 16-bit frames every unselected lane of the data field is zero.
- R7: The CRC uses polynomial 0x1021 and initial value 0xFFFF, with no reflection and no final XOR. It is computed MSB first over the 80 header, address and data bits as sent.
- R8: `in_ready` is low from the cycle after an accepting edge until the last CRC bit has been presented. It is high again in the following cycle, so back-to-back frames leave exactly one idle cycle. Requests offered while `in_ready` is low are ignored.
- R9: `ser_valid` is high for exactly 96 consecutive cycles per frame, starting the cycle after acceptance. `done` is high for exactly one cycle, the cycle right after the last bit.
- R10: With `rst` high at a clock edge, the following cycle shows `in_ready` = 1, `ser_valid` = 0, `done` = 0 and `byte_en` = 0000.
- R11: The reserved size code 11 is handled exactly as size code 10, including the header code 10.
- R12: `byte_en` is updated only when a request is accepted and holds its value until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block can take a request |
| in_hdr | input | 16 | Command header |
| in_addr | input | 32 | Target address |
| in_data | input | 32 | Write data, right aligned for narrow sizes |
| in_size | input | 2 | Size code: 00 8-bit, 01 16-bit, 10 32-bit, 11 reserved |
| byte_en | output | 4 | Lane-enable mask of the current frame |
| ser_valid | output | 1 | Bit slot strobe |
| ser_bit | output | 1 | Serial frame bit |
| done | output | 1 | One-cycle pulse after the final bit |

## Verification
The hardest case to reach is the handover between frames. A request must be taken in the single cycle after the last CRC bit, and requests offered during the busy window must be dropped. The stimulus holds `in_valid` high through a whole frame and changes the data every cycle while the block is busy. It then presents the next real request at the first cycle `in_ready` returns. The reference model must show the junk was ignored and the new frame starts one cycle after `done`. All four byte offsets, both half-word offsets, word writes with non-zero low address bits and the reserved size code are each driven explicitly, followed by a run of random requests.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } wf_size_e;

  // reserved code is folded onto the full-word transfer (R11)
  function automatic wf_size_e fold_size(input logic [1:0] code);
    if (code == SZ_RSVD) return SZ_WORD;
    return wf_size_e'(code);
  endfunction
endpackage

// File: rtl/wf_lane_map.sv
module wf_lane_map
  import wf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int SEL_W = $clog2(LANES)
) (
  input  wf_size_e          size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] lane_data
);
  localparam int HALF = LANES / 2;

  logic [SEL_W-1:0] byte_sel;
  logic             half_sel;

  // offset 0 addresses the most significant lane (R3, R4)
  assign byte_sel = SEL_W'(LANES - 1) - addr[SEL_W-1:0];
  assign half_sel = ~addr[0];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic       en;
      logic [7:0] src;
      always_comb begin
        unique case (size)
          SZ_BYTE: begin
            en  = (byte_sel == SEL_W'(g));
            src = data[7:0];
          end
          SZ_HALF: begin
            en  = ((g >= HALF) == half_sel);
            src = data[8*(g % HALF) +: 8];
          end
          default: begin
            en  = 1'b1;
            src = data[8*g +: 8];
          end
        endcase
      end
      assign lane_en[g]         = en;
      assign lane_data[8*g +: 8] = en ? src : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/wf_crc.sv
module wf_crc #(
  parameter int                MSG_W = 80,
  parameter int                CRC_W = 16,
  parameter logic [CRC_W-1:0]  POLY  = 16'h1021,
  parameter logic [CRC_W-1:0]  INIT  = 16'hFFFF
) (
  input  logic [MSG_W-1:0] msg,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] acc;
  logic             fb;

  always_comb begin
    acc = INIT;
    fb  = 1'b0;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ msg[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ POLY;
    end
    crc = acc;
  end
endmodule

// File: rtl/wf_shifter.sv
module wf_shifter #(
  parameter int FRAME_W = 96,
  localparam int CNT_W = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               ser_bit,
  output logic               done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        sh_q   <= frame;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign ser_bit = sh_q[FRAME_W-1];
  assign done    = done_q;
endmodule

// File: rtl/wr_frame_tx.sv
module wr_frame_tx
  import wf_pkg::*;
#(
  parameter int               HDR_W    = 16,
  parameter int               ADDR_W   = 32,
  parameter int               DATA_W   = 32,
  parameter int               CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  localparam int LANES   = DATA_W / 8,
  localparam int MSG_W   = HDR_W + ADDR_W + DATA_W,
  localparam int FRAME_W = MSG_W + CRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        in_size,
  output logic [LANES-1:0]  byte_en,
  output logic              ser_valid,
  output logic              ser_bit,
  output logic              done
);
  wf_size_e           size_eff;
  logic               accept;
  logic               busy;
  logic [HDR_W-1:0]   hdr_f;
  logic [LANES-1:0]   be_c;
  logic [DATA_W-1:0]  data_c;
  logic [MSG_W-1:0]   msg;
  logic [CRC_W-1:0]   crc;
  logic [LANES-1:0]   be_q;

  assign size_eff = fold_size(in_size);
  assign accept   = in_valid & ~busy;
  assign hdr_f    = {in_hdr[HDR_W-1:2], size_eff};

  wf_lane_map #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_lane (
    .size      (size_eff),
    .addr      (in_addr),
    .data      (in_data),
    .lane_en   (be_c),
    .lane_data (data_c)
  );

  assign msg = {hdr_f, in_addr, data_c};

  wf_crc #(.MSG_W(MSG_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .msg (msg),
    .crc (crc)
  );

  wf_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .frame   ({msg, crc}),
    .busy    (busy),
    .ser_bit (ser_bit),
    .done    (done)
  );

  always_ff @(posedge clk) begin
    if (rst)         be_q <= '0;
    else if (accept) be_q <= be_c;
  end

  assign in_ready  = ~busy;
  assign ser_valid = busy;
  assign byte_en   = be_q;
endmodule

// File: rtl/wf_chk.sv
module wf_chk #(
  parameter int FRAME_W = 96,
  parameter int LANES   = 4,
  localparam int RC_W = $clog2(FRAME_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_size,
  input logic [LANES-1:0] byte_en,
  input logic             ser_valid,
  input logic             done
);
  logic [RC_W-1:0] run_q;
  logic            acc;

  assign acc = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst)            run_q <= '0;
    else if (ser_valid) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  p_ready_closed_r8: assert property (@(posedge clk) disable iff (rst)
    ser_valid |-> !in_ready);
  p_accept_starts_r9: assert property (@(posedge clk) disable iff (rst)
    acc |=> ser_valid);
  p_run_bound_r9: assert property (@(posedge clk) disable iff (rst)
    ser_valid |-> (run_q < RC_W'(FRAME_W)));
  p_run_full_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_valid) |-> (run_q == RC_W'(FRAME_W)));
  p_done_follows_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_valid) |-> done);
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_byte_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    acc && in_size == 2'b00 |=> $countones(byte_en) == 1);
  p_half_pair_r4: assert property (@(posedge clk) disable iff (rst)
    acc && in_size == 2'b01 |=> (byte_en == 4'b1100 || byte_en == 4'b0011));
  p_word_all_r5: assert property (@(posedge clk) disable iff (rst)
    acc && in_size[1] |=> byte_en == 4'b1111);
  p_be_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(byte_en));
endmodule

bind wr_frame_tx wf_chk #(.FRAME_W(FRAME_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_size   (in_size),
  .byte_en   (byte_en),
  .ser_valid (ser_valid),
  .done      (done)
);

// File: tb/sim_wr_frame_tx.sv
module sim_wr_frame_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_hdr = '0;
  logic [31:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic [1:0]  in_size = '0;
  logic [3:0]  byte_en;
  logic        ser_valid;
  logic        ser_bit;
  logic        done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wr_frame_tx u0 (.*);

  // behavioural reference model
  bit    m_busy = 0;
  bit    m_sv = 0, m_done = 0, m_bit = 0;
  logic [3:0] m_be = '0;
  bit    bitq[$];
  string tagq[$];
  string m_tag = "R1";
  string be_tag = "R10";

  function automatic void build(input logic [15:0] h, input logic [31:0] a,
                                input logic [31:0] d, input logic [1:0] sz);
    logic [1:0]  code;
    logic [31:0] dd;
    logic [15:0] c;
    bit          msg[$];
    string       dtag;
    int          sh;
    code = (sz == 2'b11) ? 2'b10 : sz;
    case (code)
      2'b00: begin
        sh = 3 - int'(a[1:0]);
        m_be = 4'b0001 << sh;
        dd = {24'h0, d[7:0]} << (8 * sh);
        dtag = "R3/R6";
      end
      2'b01: begin
        if (a[0]) begin m_be = 4'b0011; dd = {16'h0, d[15:0]}; end
        else      begin m_be = 4'b1100; dd = {d[15:0], 16'h0}; end
        dtag = "R4/R6";
      end
      default: begin
        m_be = 4'b1111; dd = d;
        dtag = (sz == 2'b11) ? "R11" : "R5";
      end
    endcase
    be_tag = dtag;
    for (int i = 15; i >= 2; i--) begin msg.push_back(h[i]); tagq.push_back("R1"); end
    for (int i = 1; i >= 0; i--)  begin msg.push_back(code[i]); tagq.push_back("R2"); end
    for (int i = 31; i >= 0; i--) begin msg.push_back(a[i]); tagq.push_back("R1"); end
    for (int i = 31; i >= 0; i--) begin msg.push_back(dd[i]); tagq.push_back(dtag); end
    c = 16'hFFFF;
    foreach (msg[k]) begin
      bit fb;
      fb = c[15] ^ msg[k];
      c = c << 1;
      if (fb) c = c ^ 16'h1021;
    end
    foreach (msg[k]) bitq.push_back(msg[k]);
    for (int i = 15; i >= 0; i--) begin bitq.push_back(c[i]); tagq.push_back("R7"); end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_sv = 0; m_done = 0; m_be = '0;
      bitq.delete(); tagq.delete();
    end else begin
      m_done = 0;
      if (in_valid && !m_busy) begin
        build(in_hdr, in_addr, in_data, in_size);
        m_busy = 1; m_sv = 1;
        m_bit = bitq.pop_front(); m_tag = tagq.pop_front();
      end else if (m_busy) begin
        if (bitq.size() == 0) begin
          m_busy = 0; m_sv = 0; m_done = 1;
        end else begin
          m_bit = bitq.pop_front(); m_tag = tagq.pop_front();
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(rst ? "R10" : "R8", "in_ready", 32'(in_ready), 32'(!m_busy));
      chk(rst ? "R10" : "R9", "ser_valid", 32'(ser_valid), 32'(m_sv));
      chk(rst ? "R10" : "R9", "done", 32'(done), 32'(m_done));
      chk(rst ? "R10" : be_tag, "byte_en", 32'(byte_en), 32'(m_be));
      if (m_sv) chk(m_tag, "ser_bit", 32'(ser_bit), 32'(m_bit));
    end
  end

  task automatic send(input logic [15:0] h, input logic [31:0] a, input logic [31:0] d,
                      input logic [1:0] sz, input bit keep);
    forever begin
      @(negedge clk);
      if (in_ready) break;
      in_data = $urandom;           // junk while busy, must be ignored (R8)
      in_addr = $urandom;
      in_size = 2'($urandom);
    end
    in_hdr = h; in_addr = a; in_data = d; in_size = sz; in_valid = 1'b1;
    @(negedge clk);
    if (!keep) in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: explicit reset state
    chk("R10", "reset in_ready", 32'(in_ready), 1);
    chk("R10", "reset ser_valid", 32'(ser_valid), 0);
    chk("R10", "reset byte_en", 32'(byte_en), 0);
    rst = 1'b0;
    // R3: each byte offset
    for (int o = 0; o < 4; o++) send(16'hA5C3, 32'h1000_0000 | o, 32'hDEAD_BE00 | o, 2'b00, 0);
    // R4: both half-words
    send(16'h1234, 32'h2000_0002, 32'hFFFF_8001, 2'b01, 0);
    send(16'h4321, 32'h2000_0003, 32'hAAAA_7E55, 2'b01, 0);
    // R5: word with low address bits set
    send(16'hFFFF, 32'h3000_0003, 32'h0123_4567, 2'b10, 0);
    // R11: reserved size
    send(16'h0F0F, 32'h4000_0001, 32'h89AB_CDEF, 2'b11, 0);
    // R8/R9: valid held high, junk during busy, back-to-back handover
    send(16'h5555, 32'h5000_0000, 32'h1111_2222, 2'b10, 1);
    send(16'hAAAA, 32'h5000_0005, 32'h3333_4444, 2'b00, 1);
    send(16'h0001, 32'h5000_0006, 32'h5555_6666, 2'b01, 0);
    // mixed random requests
    for (int n = 0; n < 20; n++)
      send(16'($urandom), $urandom, $urandom, 2'($urandom), n[0]);
    in_valid = 1'b0;
    repeat (110) @(negedge clk);
    // R12: byte_en held with nothing accepted
    chk("R12", "byte_en hold", 32'(byte_en), 32'(m_be));
    finish_run();
  end
endmodule